// File: doc/BRIEF.md
# Programmable Parallel Port Interface

This block connects a CPU bus to three peripheral ports of general-purpose I/O. Port A and port B are full bytes. Port C is split into two nibbles: the upper one belongs to group A and the lower one to group B. Each of the four port groups can be set as input or output on its own, through a control register. Only the basic mode is built: there are no handshake lines and no interrupts. An output port holds the last value written to it. An input port shows its pin levels when the CPU reads it.

The CPU side has an 8-bit data bus, split into `data_i`, `data_o` and `data_oe_o`. It also has an active-low select, active-low read and write strobes, and a 2-bit register address. A write is taken on every rising clock edge at which select and write are both low; repeating it has no further effect. Read data is combinational and drives the bus only while select and read are both low. A control write has two forms. With the top bit set it is a mode word, which sets the directions and clears every output latch. With the top bit clear it sets or clears one port C bit and leaves the directions as they were.

Top module: `ppi_top`

## Requirements
- R1: While `rst_ni` is low, the control register holds 0x9B (all four groups input), every output latch is 0 and every port output enable is 0.
- R2: `data_oe_o` is 1 exactly when `cs_ni` and `rd_ni` are both 0. While it is 0, `data_o` is 0.
- R3: While `cs_ni` is 1, no register or latch changes, whatever the strobes, address and data are.
- R4: A write to address 3 with bit 7 = 1 and bits 6, 5 and 2 all 0 stores the word as the control register and clears all three output latches to 0. The direction bits are bit 4 for port A, bit 3 for port C upper, bit 1 for port B and bit 0 for port C lower, where 1 means input.
- R5: A write to address 3 with bit 7 = 1 and any of bits 6, 5 or 2 set changes neither the control register nor any latch.
- R6: A write to address 3 with bit 7 = 0 sets the port C latch bit chosen by bits 3..1 to the value of bit 0. The other port C bits, the other latches and the control register do not change.
- R7: A write to address 0, 1 or 2 loads the whole byte into the port A, port B or port C latch. `pa_o`, `pb_o` and `pc_o` always show their latch.
- R8: Reading address 0 or 1 returns the port's latch when the port is an output and the port's pins when it is an input. Reading address 2 makes that choice separately for each nibble.
- R9: Reading address 3 returns the current control register.
- R10: `pa_oe_o` and `pb_oe_o` are all ones when their port is an output and all zeros when it is an input. `pc_oe_o[7:4]` follows the port C upper direction and `pc_oe_o[3:0]` follows the port C lower direction.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| cs_ni | input | 1 | Block select, active low |
| rd_ni | input | 1 | Read strobe, active low |
| wr_ni | input | 1 | Write strobe, active low |
| addr_i | input | 2 | Register address: 0 = port A, 1 = port B, 2 = port C, 3 = control |
| data_i | input | 8 | Write data from the CPU |
| data_o | output | 8 | Read data to the CPU |
| data_oe_o | output | 1 | Drive enable for the read data |
| pa_i | input | 8 | Port A pin levels |
| pa_o | output | 8 | Port A output latch |
| pa_oe_o | output | 8 | Port A drive enables |
| pb_i | input | 8 | Port B pin levels |
| pb_o | output | 8 | Port B output latch |
| pb_oe_o | output | 8 | Port B drive enables |
| pc_i | input | 8 | Port C pin levels |
| pc_o | output | 8 | Port C output latch |
| pc_oe_o | output | 8 | Port C drive enables, upper and lower nibble controlled separately |

## Verification
The bench sets port C to mixed directions, with one nibble input and the other output. A design that picks the read source for the whole byte from one direction bit would then return pins where it should return the latch, or the reverse.

It also writes mode words that set one of the reserved bits. A design that accepts such a word would change directions and clear latches it should have left alone.

Single-bit set and reset writes are sent to all eight bit positions. A design that decodes the bit number wrongly, or lets this form touch the control register, would corrupt neighbouring bits or change directions.

Writes with the block deselected, and reads taken after a mode word has cleared the latches, catch a design that gates on the strobe alone or keeps stale output values.

// File: rtl/ppi_pkg.sv
package ppi_pkg;
  localparam int PORT_W = 8;
  localparam int NIB_W  = PORT_W / 2;
  localparam int SEL_W  = $clog2(PORT_W);
  localparam int CW_W   = 8;

  typedef enum logic [1:0] {
    SEL_PA = 2'b00,
    SEL_PB = 2'b01,
    SEL_PC = 2'b10,
    SEL_CW = 2'b11
  } reg_sel_e;

  // control word bit positions (1 = input)
  localparam int CW_FLAG  = 7;
  localparam int CW_A_IN  = 4;
  localparam int CW_CU_IN = 3;
  localparam int CW_B_IN  = 1;
  localparam int CW_CL_IN = 0;
  localparam logic [CW_W-1:0] CW_RESET = 8'h9B;

  typedef struct packed {
    logic a_in;
    logic cu_in;
    logic b_in;
    logic cl_in;
  } dir_t;
endpackage

// File: rtl/ppi_ctrl_reg.sv
module ppi_ctrl_reg
  import ppi_pkg::*;
(
  input  logic            clk_i,
  input  logic            rst_ni,
  input  logic            wr_i,
  input  logic [CW_W-1:0] wdata_i,
  output logic [CW_W-1:0] ctrl_o,
  output dir_t            dir_o,
  output logic            mode_set_o,
  output logic            bsr_o,
  output logic [SEL_W-1:0] bsr_sel_o,
  output logic            bsr_val_o
);
  logic [CW_W-1:0] ctrl_q;
  logic            mode_word;
  logic            mode_legal;

  assign mode_word  = wdata_i[CW_FLAG];
  assign mode_legal = ~(wdata_i[6] | wdata_i[5] | wdata_i[2]);
  assign mode_set_o = wr_i & mode_word & mode_legal;
  assign bsr_o      = wr_i & ~mode_word;
  assign bsr_sel_o  = wdata_i[SEL_W:1];
  assign bsr_val_o  = wdata_i[0];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)         ctrl_q <= CW_RESET;
    else if (mode_set_o) ctrl_q <= wdata_i;
  end

  assign ctrl_o      = ctrl_q;
  assign dir_o.a_in  = ctrl_q[CW_A_IN];
  assign dir_o.cu_in = ctrl_q[CW_CU_IN];
  assign dir_o.b_in  = ctrl_q[CW_B_IN];
  assign dir_o.cl_in = ctrl_q[CW_CL_IN];

  p_bad_mode_ignored_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_i && wdata_i[CW_FLAG] && (wdata_i[6] || wdata_i[5] || wdata_i[2])) |=> $stable(ctrl_q));

  p_bsr_keeps_dir_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_i && !wdata_i[CW_FLAG]) |=> $stable(ctrl_q));
endmodule

// File: rtl/ppi_latch.sv
module ppi_latch #(
  parameter int W = 8
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         clr_i,
  input  logic [W-1:0] we_i,
  input  logic [W-1:0] wdata_i,
  output logic [W-1:0] q_o
);
  logic [W-1:0] q;

  for (genvar i = 0; i < W; i++) begin : g_bit
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)       q[i] <= 1'b0;
      else if (clr_i)    q[i] <= 1'b0;
      else if (we_i[i])  q[i] <= wdata_i[i];
    end
  end

  assign q_o = q;

  p_clear_on_mode_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    clr_i |=> (q_o == '0));

  p_hold_idle_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!clr_i && we_i == '0) |=> $stable(q_o));
endmodule

// File: rtl/ppi_read_mux.sv
module ppi_read_mux
  import ppi_pkg::*;
(
  input  reg_sel_e          sel_i,
  input  dir_t              dir_i,
  input  logic [CW_W-1:0]   ctrl_i,
  input  logic [PORT_W-1:0] la_i,
  input  logic [PORT_W-1:0] lb_i,
  input  logic [PORT_W-1:0] lc_i,
  input  logic [PORT_W-1:0] pa_i,
  input  logic [PORT_W-1:0] pb_i,
  input  logic [PORT_W-1:0] pc_i,
  output logic [PORT_W-1:0] rdata_o
);
  logic [PORT_W-1:0] a_val, b_val, c_val;

  assign a_val = dir_i.a_in ? pa_i : la_i;
  assign b_val = dir_i.b_in ? pb_i : lb_i;
  assign c_val[PORT_W-1:NIB_W] = dir_i.cu_in ? pc_i[PORT_W-1:NIB_W] : lc_i[PORT_W-1:NIB_W];
  assign c_val[NIB_W-1:0]      = dir_i.cl_in ? pc_i[NIB_W-1:0]      : lc_i[NIB_W-1:0];

  always_comb begin
    unique case (sel_i)
      SEL_PA:  rdata_o = a_val;
      SEL_PB:  rdata_o = b_val;
      SEL_PC:  rdata_o = c_val;
      default: rdata_o = ctrl_i;
    endcase
  end
endmodule

// File: rtl/ppi_top.sv
module ppi_top
  import ppi_pkg::*;
(
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              cs_ni,
  input  logic              rd_ni,
  input  logic              wr_ni,
  input  logic [1:0]        addr_i,
  input  logic [CW_W-1:0]   data_i,
  output logic [CW_W-1:0]   data_o,
  output logic              data_oe_o,
  input  logic [PORT_W-1:0] pa_i,
  output logic [PORT_W-1:0] pa_o,
  output logic [PORT_W-1:0] pa_oe_o,
  input  logic [PORT_W-1:0] pb_i,
  output logic [PORT_W-1:0] pb_o,
  output logic [PORT_W-1:0] pb_oe_o,
  input  logic [PORT_W-1:0] pc_i,
  output logic [PORT_W-1:0] pc_o,
  output logic [PORT_W-1:0] pc_oe_o
);
  reg_sel_e          sel;
  logic              wr_en, rd_en;
  logic [CW_W-1:0]   ctrl;
  dir_t              dir;
  logic              mode_set, bsr;
  logic [SEL_W-1:0]  bsr_sel;
  logic              bsr_val;
  logic [PORT_W-1:0] la, lb, lc;
  logic [PORT_W-1:0] pa_we, pb_we, pc_we, pc_wdata;
  logic [PORT_W-1:0] rdata;

  assign sel   = reg_sel_e'(addr_i);
  assign wr_en = ~cs_ni & ~wr_ni;
  assign rd_en = ~cs_ni & ~rd_ni;

  ppi_ctrl_reg u_ctrl (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .wr_i       (wr_en && sel == SEL_CW),
    .wdata_i    (data_i),
    .ctrl_o     (ctrl),
    .dir_o      (dir),
    .mode_set_o (mode_set),
    .bsr_o      (bsr),
    .bsr_sel_o  (bsr_sel),
    .bsr_val_o  (bsr_val)
  );

  assign pa_we = {PORT_W{wr_en && sel == SEL_PA}};
  assign pb_we = {PORT_W{wr_en && sel == SEL_PB}};

  always_comb begin
    if (wr_en && sel == SEL_PC) begin
      pc_we    = '1;
      pc_wdata = data_i;
    end else if (bsr) begin
      pc_we    = PORT_W'(1) << bsr_sel;
      pc_wdata = {PORT_W{bsr_val}};
    end else begin
      pc_we    = '0;
      pc_wdata = data_i;
    end
  end

  ppi_latch #(.W(PORT_W)) u_la (
    .clk_i(clk_i), .rst_ni(rst_ni), .clr_i(mode_set), .we_i(pa_we), .wdata_i(data_i), .q_o(la));
  ppi_latch #(.W(PORT_W)) u_lb (
    .clk_i(clk_i), .rst_ni(rst_ni), .clr_i(mode_set), .we_i(pb_we), .wdata_i(data_i), .q_o(lb));
  ppi_latch #(.W(PORT_W)) u_lc (
    .clk_i(clk_i), .rst_ni(rst_ni), .clr_i(mode_set), .we_i(pc_we), .wdata_i(pc_wdata), .q_o(lc));

  ppi_read_mux u_rmux (
    .sel_i   (sel),
    .dir_i   (dir),
    .ctrl_i  (ctrl),
    .la_i    (la),
    .lb_i    (lb),
    .lc_i    (lc),
    .pa_i    (pa_i),
    .pb_i    (pb_i),
    .pc_i    (pc_i),
    .rdata_o (rdata)
  );

  assign data_oe_o = rd_en;
  assign data_o    = rd_en ? rdata : '0;

  assign pa_o    = la;
  assign pb_o    = lb;
  assign pc_o    = lc;
  assign pa_oe_o = {PORT_W{~dir.a_in}};
  assign pb_oe_o = {PORT_W{~dir.b_in}};
  assign pc_oe_o = {{NIB_W{~dir.cu_in}}, {NIB_W{~dir.cl_in}}};

  p_deselected_frozen_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cs_ni |=> ($stable(ctrl) && $stable(la) && $stable(lb) && $stable(lc)));

  p_bsr_single_bit_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    bsr |=> ($countones(lc ^ $past(lc)) <= 1 && $stable(la) && $stable(lb)));
endmodule

// File: tb/ppi_top_bench.sv
module ppi_top_bench;
  localparam int CLK_PERIOD = 10;

  logic       clk_i = 1'b0;
  logic       rst_ni = 1'b0;
  logic       cs_ni = 1'b1, rd_ni = 1'b1, wr_ni = 1'b1;
  logic [1:0] addr_i = '0;
  logic [7:0] data_i = '0;
  logic [7:0] data_o;
  logic       data_oe_o;
  logic [7:0] pa_i = '0, pb_i = '0, pc_i = '0;
  logic [7:0] pa_o, pa_oe_o, pb_o, pb_oe_o, pc_o, pc_oe_o;

  int checks = 0;
  int fails  = 0;

  logic [7:0] m_ctrl, m_la, m_lb, m_lc;

  always #(CLK_PERIOD/2) clk_i = ~clk_i;

  ppi_top u_ppi_top (
    .clk_i(clk_i), .rst_ni(rst_ni), .cs_ni(cs_ni), .rd_ni(rd_ni), .wr_ni(wr_ni),
    .addr_i(addr_i), .data_i(data_i), .data_o(data_o), .data_oe_o(data_oe_o),
    .pa_i(pa_i), .pa_o(pa_o), .pa_oe_o(pa_oe_o),
    .pb_i(pb_i), .pb_o(pb_o), .pb_oe_o(pb_oe_o),
    .pc_i(pc_i), .pc_o(pc_o), .pc_oe_o(pc_oe_o)
  );

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  function automatic void model_reset();
    m_ctrl = 8'h9B; m_la = '0; m_lb = '0; m_lc = '0;
  endfunction

  function automatic void model_write(input logic [1:0] a, input logic [7:0] d);
    case (a)
      2'd0: m_la = d;
      2'd1: m_lb = d;
      2'd2: m_lc = d;
      default: begin
        if (d[7]) begin
          if (!d[6] && !d[5] && !d[2]) begin
            m_ctrl = d; m_la = '0; m_lb = '0; m_lc = '0;
          end
        end else m_lc[d[3:1]] = d[0];
      end
    endcase
  endfunction

  function automatic logic [7:0] exp_read(input logic [1:0] a);
    case (a)
      2'd0: return m_ctrl[4] ? pa_i : m_la;
      2'd1: return m_ctrl[1] ? pb_i : m_lb;
      2'd2: return {m_ctrl[3] ? pc_i[7:4] : m_lc[7:4], m_ctrl[0] ? pc_i[3:0] : m_lc[3:0]};
      default: return m_ctrl;
    endcase
  endfunction

  task automatic bus_write(input logic [1:0] a, input logic [7:0] d, input logic sel);
    @(negedge clk_i);
    cs_ni = ~sel; wr_ni = 1'b0; addr_i = a; data_i = d;
    @(negedge clk_i);
    cs_ni = 1'b1; wr_ni = 1'b1;
    if (sel) model_write(a, d);
  endtask

  task automatic bus_read(input logic [1:0] a, input string req);
    @(negedge clk_i);
    cs_ni = 1'b0; rd_ni = 1'b0; addr_i = a;
    #1;
    chk("R2 read enable", data_oe_o, 1'b1);
    chk(req, data_o, exp_read(a));
    @(negedge clk_i);
    cs_ni = 1'b1; rd_ni = 1'b1;
    #1;
    chk("R2 idle bus", {data_oe_o, data_o}, 9'h0);
  endtask

  task automatic check_pins();
    #1;
    chk("R7 pa_o", pa_o, m_la);
    chk("R7 pb_o", pb_o, m_lb);
    chk("R7 pc_o", pc_o, m_lc);
    chk("R10 pa_oe", pa_oe_o, {8{~m_ctrl[4]}});
    chk("R10 pb_oe", pb_oe_o, {8{~m_ctrl[1]}});
    chk("R10 pc_oe", pc_oe_o, {{4{~m_ctrl[3]}}, {4{~m_ctrl[0]}}});
  endtask

  initial begin
    #(CLK_PERIOD * 150000);
    fails++;
    $display("FAIL watchdog: actual hung expected done");
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    void'($urandom(32'h5eed_1234));
    model_reset();
    repeat (3) @(negedge clk_i);
    #1;
    chk("R1 latches in reset", {pa_o, pb_o, pc_o}, 24'h0);
    chk("R1 oe in reset", {pa_oe_o, pb_oe_o, pc_oe_o}, 24'h0);
    @(negedge clk_i);
    rst_ni = 1'b1;
    pa_i = 8'hA5; pb_i = 8'h3C; pc_i = 8'hE1;
    bus_read(2'd3, "R1 R9 control after reset");
    bus_read(2'd0, "R8 input port A reads pins");
    bus_read(2'd2, "R8 input port C reads pins");

    // deselected read keeps bus off
    @(negedge clk_i);
    cs_ni = 1'b1; rd_ni = 1'b0; #1;
    chk("R2 deselected read", {data_oe_o, data_o}, 9'h0);
    rd_ni = 1'b1;

    // R4 all outputs
    bus_write(2'd3, 8'h80, 1'b1);
    check_pins();
    bus_write(2'd0, 8'h5A, 1'b1);
    bus_write(2'd1, 8'hC3, 1'b1);
    bus_write(2'd2, 8'h96, 1'b1);
    check_pins();
    bus_read(2'd0, "R8 output port A reads latch");
    bus_read(2'd1, "R8 output port B reads latch");

    // R3 deselected writes
    bus_write(2'd0, 8'hFF, 1'b0);
    bus_write(2'd3, 8'h9B, 1'b0);
    bus_write(2'd3, 8'h01, 1'b0);
    check_pins();
    bus_read(2'd3, "R3 control unchanged when deselected");
    bus_read(2'd0, "R3 latch unchanged when deselected");

    // R5 reserved bits
    bus_write(2'd3, 8'hC0, 1'b1);
    bus_write(2'd3, 8'hA9, 1'b1);
    bus_write(2'd3, 8'h84, 1'b1);
    check_pins();
    bus_read(2'd3, "R5 illegal mode word ignored");
    bus_read(2'd2, "R5 latch kept after illegal word");

    // R6 every bit position, mixed port C directions
    bus_write(2'd3, 8'h88, 1'b1);  // C upper input, C lower output
    bus_write(2'd2, 8'h00, 1'b1);
    for (int b = 0; b < 8; b++) begin
      bus_write(2'd3, {4'b0000, 3'(b), 1'b1}, 1'b1);
      check_pins();
    end
    for (int b = 0; b < 8; b += 2) begin
      bus_write(2'd3, {4'b0000, 3'(b), 1'b0}, 1'b1);
      check_pins();
    end
    bus_read(2'd3, "R6 bit set keeps control");
    bus_read(2'd2, "R8 mixed nibble read");
    bus_write(2'd3, 8'h81, 1'b1);  // C upper output, C lower input
    bus_write(2'd2, 8'h7E, 1'b1);
    bus_read(2'd2, "R8 mixed nibble read swapped");
    check_pins();

    // random phase
    for (int i = 0; i < 600; i++) begin
      int op;
      logic [7:0] d;
      pa_i = 8'($urandom); pb_i = 8'($urandom); pc_i = 8'($urandom);
      op = $urandom_range(0, 5);
      d  = 8'($urandom);
      case (op)
        0: bus_write(2'($urandom), d, 1'b1);
        1: bus_write(2'd3, {1'b1, 2'b00, d[4:3], 1'b0, d[1:0]}, 1'b1);
        2: bus_write(2'd3, {1'b0, d[6:0]}, 1'b1);
        3: bus_write(2'($urandom), d, 1'b0);
        default: bus_read(2'($urandom), "R8 R9 random read");
      endcase
      check_pins();
    end

    // mid-run reset
    @(negedge clk_i);
    rst_ni = 1'b0;
    model_reset();
    #1;
    chk("R1 async reset latches", {pa_o, pb_o, pc_o}, 24'h0);
    chk("R1 async reset oe", {pa_oe_o, pb_oe_o, pc_oe_o}, 24'h0);
    @(negedge clk_i);
    rst_ni = 1'b1;
    bus_read(2'd3, "R1 control after second reset");

    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule